// File: doc/BRIEF.md
# Trap Return Status Update Unit

This unit resolves the two privileged return instructions of a processor core: the return from a supervisor-level trap and the return from a machine-level trap. Each request brings the current privilege level, the live interrupt-enable and previous-privilege status bits, the trap-supervisor-return control bit, both saved exception PCs and a flag that says whether compressed instructions are enabled. One clock later the unit answers with either an exception cause or the resumption PC, the privilege level to enter and the rewritten status bits. The core writes these back into its status register.

A return first passes three checks, in a fixed order. The first is the privilege check, the second is the alignment check on the saved PC, and the third is the trap-supervisor-return control. If a check fails, the unit reports only the cause and passes every status bit through unchanged. If all checks pass, the unit pops the one-deep stack that a trap pushed. The enable bit of the target level is restored from its saved copy, the saved copy is set to 1, and the saved privilege is cleared to user after it has been used as the new privilege.

Top module: `trap_return_unit`

## Requirements
- R1: A supervisor return (`ret_kind_i` = 0) issued at a privilege numerically below supervisor, that is at user (2'b00), faults with cause 2. Privilege codes are user 2'b00, supervisor 2'b01 and machine 2'b11.
- R2: A machine return (`ret_kind_i` = 1) issued at any privilege other than machine (2'b11) faults with cause 2.
- R3: When `compressed_en_i` is 0 and bit 0 or bit 1 of the selected saved PC is set, the return faults with cause 0. When `compressed_en_i` is 1, the low PC bits never cause a fault.
- R4: A supervisor return with `tsr_i` = 1 faults with cause 2 unless the current privilege is machine. At machine privilege the `tsr_i` bit has no effect.
- R5: A supervisor return that passes the checks gives `sie_o` = `spie_i`, `spie_o` = 1 and `spp_o` = 0. `new_priv_o` is supervisor (2'b01) if `spp_i` = 1 and user (2'b00) if `spp_i` = 0. `ret_pc_o` = `sepc_i`.
- R6: A machine return that passes the checks gives `mie_o` = `mpie_i`, `mpie_o` = 1, `mpp_o` = 2'b00, `new_priv_o` = `mpp_i` and `ret_pc_o` = `mepc_i`.
- R7: On any fault, every status output equals its input, `new_priv_o` equals `cur_priv_i` and `ret_pc_o` is 0. A successful return reports `fault_o` = 0 and `cause_o` = 0.
- R8: Where several checks fail at once, the privilege check wins over the alignment check, and the alignment check wins over the trap-supervisor-return check.
- R9: `rsp_valid_o` is high in exactly the cycle after a cycle in which `req_valid_i` was high. It is low out of reset.
- R10: A supervisor return leaves `mie_o`, `mpie_o` and `mpp_o` equal to their inputs. A machine return leaves `sie_o`, `spie_o` and `spp_o` equal to their inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | A return instruction is presented this cycle |
| ret_kind_i | input | 1 | 0 = supervisor return, 1 = machine return |
| cur_priv_i | input | 2 | Current privilege level |
| compressed_en_i | input | 1 | Compressed instructions enabled (relaxes the alignment check) |
| tsr_i | input | 1 | Trap-supervisor-return control bit |
| sie_i | input | 1 | Supervisor interrupt enable |
| spie_i | input | 1 | Supervisor saved interrupt enable |
| spp_i | input | 1 | Supervisor saved privilege (0 user, 1 supervisor) |
| mie_i | input | 1 | Machine interrupt enable |
| mpie_i | input | 1 | Machine saved interrupt enable |
| mpp_i | input | 2 | Machine saved privilege |
| sepc_i | input | XLEN | Saved supervisor exception PC |
| mepc_i | input | XLEN | Saved machine exception PC |
| rsp_valid_o | output | 1 | Result valid |
| fault_o | output | 1 | The return raised an exception |
| cause_o | output | CAUSE_W | Exception cause (0 when no fault) |
| ret_pc_o | output | XLEN | PC to resume at (0 on fault) |
| new_priv_o | output | 2 | Privilege to enter |
| sie_o | output | 1 | Updated supervisor interrupt enable |
| spie_o | output | 1 | Updated supervisor saved enable |
| spp_o | output | 1 | Updated supervisor saved privilege |
| mie_o | output | 1 | Updated machine interrupt enable |
| mpie_o | output | 1 | Updated machine saved enable |
| mpp_o | output | 2 | Updated machine saved privilege |

## Verification
A return can fail several checks at once, and only one cause may be reported. The bench therefore builds requests that fail two or three checks together. Examples are a supervisor return from user mode with a misaligned saved PC and the trap-supervisor-return bit set, and a supervisor return from supervisor mode that is both misaligned and trapped by that bit. Each cause is judged against the fixed order privilege, then alignment, then the trap-supervisor-return control. The same requests confirm that no status bit moves when a fault is reported. The same cycle can also carry a successful stack pop, and the bench checks that the fields of the other privilege level stay unchanged.

// File: rtl/trp_pkg.sv
package trp_pkg;

   localparam int PRIV_W = 2;

   localparam logic [PRIV_W-1:0] PRIV_USER  = 2'b00;
   localparam logic [PRIV_W-1:0] PRIV_SUPER = 2'b01;
   localparam logic [PRIV_W-1:0] PRIV_MACH  = 2'b11;

   typedef enum logic {
      RET_SUPER = 1'b0,
      RET_MACH  = 1'b1
   } ret_kind_e;

   typedef struct packed {
      logic              sie;
      logic              spie;
      logic              spp;
      logic              mie;
      logic              mpie;
      logic [PRIV_W-1:0] mpp;
   } ie_stack_t;

   // alignment check variants
   localparam int ALIGN_RUNTIME   = 0;
   localparam int ALIGN_ALWAYS_C  = 1;
   localparam int ALIGN_NEVER_C   = 2;

endpackage

// File: rtl/trp_perm_check.sv
module trp_perm_check
   import trp_pkg::*;
(
   input  ret_kind_e         kind_i,
   input  logic [PRIV_W-1:0] priv_i,
   input  logic              tsr_i,
   output logic              priv_fault_o,
   output logic              tsr_fault_o
);

   always_comb begin
      priv_fault_o = 1'b0;
      tsr_fault_o  = 1'b0;
      if (kind_i == RET_SUPER) begin
         priv_fault_o = (priv_i < PRIV_SUPER);
         tsr_fault_o  = tsr_i && (priv_i != PRIV_MACH);
      end else begin
         priv_fault_o = (priv_i != PRIV_MACH);
      end
   end

endmodule

// File: rtl/trp_align_check.sv
module trp_align_check #(
   parameter int XLEN       = 32,
   parameter int ALIGN_MODE = 0
) (
   input  logic [XLEN-1:0] pc_i,
   input  logic            compressed_en_i,
   output logic            misalign_o
);
   import trp_pkg::*;

   localparam int LOW_BITS = 2;

   if (XLEN <= LOW_BITS) begin : g_bad_xlen
      $error("trp_align_check: XLEN must exceed the checked low bits");
   end

   logic low_set;
   assign low_set = |pc_i[LOW_BITS-1:0];

   if (ALIGN_MODE == ALIGN_RUNTIME) begin : g_runtime
      assign misalign_o = !compressed_en_i && low_set;
   end else if (ALIGN_MODE == ALIGN_ALWAYS_C) begin : g_always_c
      logic unused_ok;
      assign unused_ok  = compressed_en_i ^ low_set;
      assign misalign_o = 1'b0;
   end else if (ALIGN_MODE == ALIGN_NEVER_C) begin : g_never_c
      logic unused_ok;
      assign unused_ok  = compressed_en_i;
      assign misalign_o = low_set;
   end else begin : g_bad_mode
      $error("trp_align_check: unknown ALIGN_MODE");
   end

endmodule

// File: rtl/trp_stack_pop.sv
module trp_stack_pop
   import trp_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  ret_kind_e         kind_i,
   input  ie_stack_t         stk_i,
   input  logic [XLEN-1:0]   sepc_i,
   input  logic [XLEN-1:0]   mepc_i,
   output ie_stack_t         stk_o,
   output logic [XLEN-1:0]   pc_o,
   output logic [PRIV_W-1:0] priv_o
);

   always_comb begin
      stk_o = stk_i;
      if (kind_i == RET_SUPER) begin
         stk_o.sie  = stk_i.spie;
         stk_o.spie = 1'b1;
         stk_o.spp  = 1'b0;
         priv_o     = stk_i.spp ? PRIV_SUPER : PRIV_USER;
         pc_o       = sepc_i;
      end else begin
         stk_o.mie  = stk_i.mpie;
         stk_o.mpie = 1'b1;
         stk_o.mpp  = PRIV_USER;
         priv_o     = stk_i.mpp;
         pc_o       = mepc_i;
      end
   end

endmodule

// File: rtl/trap_return_unit.sv
module trap_return_unit
   import trp_pkg::*;
#(
   parameter int          XLEN          = 32,
   parameter int          CAUSE_W       = 4,
   parameter int          ALIGN_MODE    = ALIGN_RUNTIME,
   parameter int unsigned ILLEGAL_CAUSE = 2,
   parameter int unsigned MISALN_CAUSE  = 0
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               req_valid_i,
   input  logic               ret_kind_i,
   input  logic [1:0]         cur_priv_i,
   input  logic               compressed_en_i,
   input  logic               tsr_i,
   input  logic               sie_i,
   input  logic               spie_i,
   input  logic               spp_i,
   input  logic               mie_i,
   input  logic               mpie_i,
   input  logic [1:0]         mpp_i,
   input  logic [XLEN-1:0]    sepc_i,
   input  logic [XLEN-1:0]    mepc_i,
   output logic               rsp_valid_o,
   output logic               fault_o,
   output logic [CAUSE_W-1:0] cause_o,
   output logic [XLEN-1:0]    ret_pc_o,
   output logic [1:0]         new_priv_o,
   output logic               sie_o,
   output logic               spie_o,
   output logic               spp_o,
   output logic               mie_o,
   output logic               mpie_o,
   output logic [1:0]         mpp_o
);

   localparam int CAUSE_LIMIT = 1 << CAUSE_W;

   if (XLEN < 8) begin : g_bad_xlen
      $error("trap_return_unit: XLEN too small");
   end
   if (CAUSE_W < 1 || ILLEGAL_CAUSE >= CAUSE_LIMIT || MISALN_CAUSE >= CAUSE_LIMIT) begin : g_bad_cause
      $error("trap_return_unit: cause codes do not fit CAUSE_W");
   end
   if (ILLEGAL_CAUSE == MISALN_CAUSE) begin : g_same_cause
      $error("trap_return_unit: cause codes must differ");
   end

   localparam logic [CAUSE_W-1:0] ILL_C = CAUSE_W'(ILLEGAL_CAUSE);
   localparam logic [CAUSE_W-1:0] MIS_C = CAUSE_W'(MISALN_CAUSE);

   ret_kind_e kind;
   ie_stack_t stk_in, stk_pop;
   logic [XLEN-1:0]   sel_pc, pop_pc;
   logic [PRIV_W-1:0] pop_priv;
   logic priv_fault, tsr_fault, misalign;

   assign kind   = ret_kind_e'(ret_kind_i);
   assign stk_in = '{sie: sie_i, spie: spie_i, spp: spp_i,
                     mie: mie_i, mpie: mpie_i, mpp: mpp_i};
   assign sel_pc = (kind == RET_MACH) ? mepc_i : sepc_i;

   trp_perm_check u_perm (
      .kind_i       (kind),
      .priv_i       (cur_priv_i),
      .tsr_i        (tsr_i),
      .priv_fault_o (priv_fault),
      .tsr_fault_o  (tsr_fault)
   );

   trp_align_check #(.XLEN(XLEN), .ALIGN_MODE(ALIGN_MODE)) u_align (
      .pc_i            (sel_pc),
      .compressed_en_i (compressed_en_i),
      .misalign_o      (misalign)
   );

   trp_stack_pop #(.XLEN(XLEN)) u_pop (
      .kind_i (kind),
      .stk_i  (stk_in),
      .sepc_i (sepc_i),
      .mepc_i (mepc_i),
      .stk_o  (stk_pop),
      .pc_o   (pop_pc),
      .priv_o (pop_priv)
   );

   // priority resolve: privilege, then alignment, then TSR
   logic               nxt_fault;
   logic [CAUSE_W-1:0] nxt_cause;
   always_comb begin
      nxt_fault = 1'b1;
      nxt_cause = '0;
      if (priv_fault)     nxt_cause = ILL_C;
      else if (misalign)  nxt_cause = MIS_C;
      else if (tsr_fault) nxt_cause = ILL_C;
      else                nxt_fault = 1'b0;
   end

   ie_stack_t stk_q;
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         rsp_valid_o <= 1'b0;
         fault_o     <= 1'b0;
         cause_o     <= '0;
         ret_pc_o    <= '0;
         new_priv_o  <= PRIV_MACH;
         stk_q       <= '0;
      end else begin
         rsp_valid_o <= req_valid_i;
         if (req_valid_i) begin
            fault_o    <= nxt_fault;
            cause_o    <= nxt_cause;
            ret_pc_o   <= nxt_fault ? '0 : pop_pc;
            new_priv_o <= nxt_fault ? cur_priv_i : pop_priv;
            stk_q      <= nxt_fault ? stk_in : stk_pop;
         end
      end
   end

   assign sie_o  = stk_q.sie;
   assign spie_o = stk_q.spie;
   assign spp_o  = stk_q.spp;
   assign mie_o  = stk_q.mie;
   assign mpie_o = stk_q.mpie;
   assign mpp_o  = stk_q.mpp;

   // ---------------- assertions ----------------
   assert_valid_follows_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_valid_i |=> rsp_valid_o);
   assert_valid_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !req_valid_i |=> !rsp_valid_o);
   assert_sret_low_priv_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && !ret_kind_i && cur_priv_i == PRIV_USER)
      |=> (fault_o && cause_o == ILL_C));
   assert_mret_low_priv_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && ret_kind_i && cur_priv_i != PRIV_MACH)
      |=> (fault_o && cause_o == ILL_C));
   assert_c_relaxes_align_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && compressed_en_i && ALIGN_MODE == ALIGN_RUNTIME)
      |=> !(fault_o && cause_o == MIS_C));
   assert_fault_holds_status_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i ##1 fault_o)
      |-> (sie_o == $past(sie_i) && spie_o == $past(spie_i) && spp_o == $past(spp_i)
           && mie_o == $past(mie_i) && mpie_o == $past(mpie_i) && mpp_o == $past(mpp_i)
           && new_priv_o == $past(cur_priv_i)));
   assert_sret_pop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && !ret_kind_i ##1 !fault_o)
      |-> (spie_o && !spp_o && sie_o == $past(spie_i) && ret_pc_o == $past(sepc_i)));
   assert_mret_pop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && ret_kind_i ##1 !fault_o)
      |-> (mpie_o && mpp_o == PRIV_USER && new_priv_o == $past(mpp_i)
           && ret_pc_o == $past(mepc_i)));

endmodule

// File: tb/trap_return_unit_tb_top.sv
module trap_return_unit_tb_top;

   localparam int XLEN = 32;
   localparam int CW   = 4;

   logic clk = 1'b0;
   always #2 clk = ~clk;   // 250 MHz

   logic            rst_n;
   logic            req_valid, kind, c_en, tsr;
   logic [1:0]      priv;
   logic            sie, spie, spp, mie, mpie;
   logic [1:0]      mpp;
   logic [XLEN-1:0] sepc, mepc;

   logic            rsp_valid, fault;
   logic [CW-1:0]   cause;
   logic [XLEN-1:0] ret_pc;
   logic [1:0]      new_priv, mpp_o;
   logic            sie_o, spie_o, spp_o, mie_o, mpie_o;

   trap_return_unit dut_i (
      .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .ret_kind_i(kind),
      .cur_priv_i(priv), .compressed_en_i(c_en), .tsr_i(tsr),
      .sie_i(sie), .spie_i(spie), .spp_i(spp), .mie_i(mie), .mpie_i(mpie), .mpp_i(mpp),
      .sepc_i(sepc), .mepc_i(mepc),
      .rsp_valid_o(rsp_valid), .fault_o(fault), .cause_o(cause), .ret_pc_o(ret_pc),
      .new_priv_o(new_priv), .sie_o(sie_o), .spie_o(spie_o), .spp_o(spp_o),
      .mie_o(mie_o), .mpie_o(mpie_o), .mpp_o(mpp_o)
   );

   localparam int RW = 1 + CW + XLEN + 2 + 5 + 2;
   typedef struct {
      logic [RW-1:0] val;
      string         tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_cmp = 0;
   int   n_bad = 0;

   function automatic logic [RW-1:0] model(
      logic k, logic [1:0] p, logic ce, logic t,
      logic a_sie, logic a_spie, logic a_spp, logic a_mie, logic a_mpie, logic [1:0] a_mpp,
      logic [XLEN-1:0] se, logic [XLEN-1:0] me);
      logic [XLEN-1:0] pc = k ? me : se;
      logic f = 1'b1;
      logic [CW-1:0] c = '0;
      logic [1:0] np = p;
      logic [XLEN-1:0] rp = '0;
      logic [6:0] st = {a_sie, a_spie, a_spp, a_mie, a_mpie, a_mpp};
      if (!k && p < 2'b01)               c = 4'd2;   // R1, R8
      else if (k && p != 2'b11)          c = 4'd2;   // R2, R8
      else if (!ce && pc[1:0] != 2'b00)  c = 4'd0;   // R3
      else if (!k && t && p != 2'b11)    c = 4'd2;   // R4
      else                               f = 1'b0;
      if (!f) begin
         rp = pc;
         if (!k) begin               // R5, R10
            np = a_spp ? 2'b01 : 2'b00;
            st = {a_spie, 1'b1, 1'b0, a_mie, a_mpie, a_mpp};
         end else begin              // R6, R10
            np = a_mpp;
            st = {a_sie, a_spie, a_spp, a_mpie, 1'b1, 2'b00};
         end
      end
      return {f, c, rp, np, st};
   endfunction

   task automatic send(logic k, logic [1:0] p, logic ce, logic t,
                       logic [6:0] st, logic [XLEN-1:0] se, logic [XLEN-1:0] me,
                       string tag);
      exp_t e;
      @(negedge clk);
      req_valid = 1'b1; kind = k; priv = p; c_en = ce; tsr = t;
      {sie, spie, spp, mie, mpie, mpp} = st;
      sepc = se; mepc = me;
      e.val = model(k, p, ce, t, st[6], st[5], st[4], st[3], st[2], st[1:0], se, me);
      e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic idle();
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         logic [RW-1:0] got;
         got = {fault, cause, ret_pc, new_priv, sie_o, spie_o, spp_o, mie_o, mpie_o, mpp_o};
         n_cmp++;
         if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL R9: unexpected response got %h expected none", got);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            if (got !== e.val) begin
               n_bad++;
               $display("FAIL %s: got %h expected %h", e.tag, got, e.val);
            end
         end
      end
   end

   initial begin
      fork
         begin
            repeat (20000) @(posedge clk);
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
         end
      join_none
   end

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; kind = 1'b0; priv = 2'b11; c_en = 1'b0; tsr = 1'b0;
      {sie, spie, spp, mie, mpie, mpp} = '0; sepc = '0; mepc = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      n_cmp++;
      if (rsp_valid !== 1'b0) begin
         n_bad++;
         $display("FAIL R9 reset: got %b expected 0", rsp_valid);
      end

      // R1: sret from user
      send(0, 2'b00, 1, 0, 7'b0110011, 32'h100, 32'h200, "R1");
      // R2: mret from supervisor and user
      send(1, 2'b01, 1, 0, 7'b0000111, 32'h100, 32'h200, "R2");
      send(1, 2'b00, 1, 0, 7'b1111111, 32'h100, 32'h200, "R2");
      idle();
      // R3: misaligned, no compressed
      send(1, 2'b11, 0, 0, 7'b0000101, 32'h100, 32'h202, "R3");
      send(0, 2'b11, 0, 0, 7'b0110000, 32'h101, 32'h200, "R3");
      // R3: compressed relaxes
      send(1, 2'b11, 1, 0, 7'b0000101, 32'h100, 32'h203, "R3");
      send(0, 2'b01, 1, 0, 7'b0110000, 32'h102, 32'h200, "R3");
      // R4: TSR at supervisor traps, at machine ignored
      send(0, 2'b01, 1, 1, 7'b0111111, 32'h104, 32'h200, "R4");
      send(0, 2'b11, 1, 1, 7'b0111111, 32'h104, 32'h200, "R4");
      idle(); idle();
      // R5: sret pops
      send(0, 2'b01, 0, 0, 7'b0110000, 32'h3000, 32'h4000, "R5");
      send(0, 2'b11, 0, 0, 7'b1000000, 32'h3004, 32'h4000, "R5");
      // R6: mret pops to each mpp value
      send(1, 2'b11, 0, 0, 7'b0000100, 32'h1000, 32'h5000, "R6");
      send(1, 2'b11, 0, 0, 7'b0001001, 32'h1000, 32'h5008, "R6");
      send(1, 2'b11, 0, 0, 7'b1110111, 32'h1000, 32'h500c, "R6");
      // R8: combined faults
      send(0, 2'b00, 0, 1, 7'b0100000, 32'h3, 32'h0, "R8");
      send(0, 2'b01, 0, 1, 7'b0100000, 32'h2, 32'h0, "R8");
      send(1, 2'b01, 0, 0, 7'b0000100, 32'h0, 32'h1, "R8");
      // R7 / R10: status pass-through and isolation
      send(1, 2'b00, 0, 0, 7'b1011011, 32'h8, 32'h9, "R7");
      send(0, 2'b01, 1, 0, 7'b0101010, 32'h8, 32'h9, "R10");
      send(1, 2'b11, 1, 0, 7'b1010010, 32'h8, 32'h9, "R10");
      idle();
      // mixed random traffic
      for (int i = 0; i < 300; i++) begin
         if ($urandom_range(3) == 0) idle();
         else send($urandom_range(1), 2'($urandom_range(3)), 1'($urandom_range(1)),
                   1'($urandom_range(1)), 7'($urandom), $urandom, $urandom, "R8 mixed");
      end
      idle(); idle(); idle();
      n_cmp++;
      if (exp_q.size() != 0) begin
         n_bad++;
         $display("FAIL R9: got %0d pending expected 0", exp_q.size());
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule